// File: doc/BRIEF.md
# Streaming Line Rasterizer

The block turns a pair of integer endpoints into the ordered run of pixel coordinates that best approximates the straight segment between them. It emits one pixel per clock cycle. A client waits for `ready`, presents both endpoints and pulses `start`. The block then streams pixels, each one marked by `pixValid`, beginning at the start point and ending at the end point. A one-cycle `done` pulse follows the last pixel, and after that `ready` returns.

The datapath uses integer addition, subtraction, a left shift, comparisons, absolute value and multiplexing, with no multiplier or divider. One loop carries a single error term that is shared by both axes. From that term it decides, every cycle, whether x, y or both advance toward the end point. It covers all eight octants, including horizontal, vertical and single-point segments. Coordinate width is a parameter, and the internal difference and error registers carry extra sign bits so that endpoints anywhere in the coordinate range cannot overflow.

Top module: `line_raster`

## Requirements
- R1: While reset is asserted and directly after it, `ready` is 1, `pixValid` is 0 and `done` is 0. Reset acts asynchronously and is active high.
- R2: If `start` is sampled high while `ready` is 1, the endpoints are captured on that edge. In the next cycle `ready` is 0 and the first pixel, equal to the start point, is presented with `pixValid` at 1.
- R3: While a line is being drawn, a new pixel is presented in every cycle. Each pixel differs from the one before it by at most 1 in each coordinate, and at least one coordinate changes.
- R4: The pixel sequence follows this error rule. dx = |x1-x0|, dy = -|y1-y0|, the x step is +1 when x1 >= x0 and -1 otherwise, the y step likewise, and err starts at dx+dy. In each step e2 = 2*err. If e2 >= dy, then err += dy and x moves by its step. If e2 <= dx, then err += dx and y moves by its step. Both tests use the same e2.
- R5: The last pixel with `pixValid` equals the end point. A line emits exactly max(|x1-x0|, |y1-y0|) + 1 pixels.
- R6: A line whose start equals its end emits exactly one valid pixel, followed by `done`.
- R7: `done` is 1 for exactly one cycle, the cycle right after the last valid pixel. During that cycle `pixValid` and `ready` are 0, and `ready` is 1 again in the following cycle.
- R8: `start` has no effect while `ready` is 0. That covers both the drawing cycles and the `done` cycle: the current pixel stream is unaltered and no new line begins after `done`.
- R9: Lines in all eight octants, horizontal and vertical lines, and lines between the extreme coordinates 0 and 2^COORD_W-1 are all produced correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Begin a new line; taken only while `ready` is 1 |
| xStart | input | COORD_W | Start point x |
| yStart | input | COORD_W | Start point y |
| xEnd | input | COORD_W | End point x |
| yEnd | input | COORD_W | End point y |
| ready | output | 1 | Idle and able to accept endpoints |
| pixValid | output | 1 | `pixX`/`pixY` hold a pixel of the line |
| pixX | output | COORD_W | Current pixel x |
| pixY | output | COORD_W | Current pixel y |
| done | output | 1 | One-cycle pulse after the final pixel |

## Verification
A corrupted error term or step direction first shows up as a wrong pixel coordinate in the same cycle in which the faulty step is taken. The bench compares every pixel against its own run of the error rule, so such a fault is flagged at the first diverging pixel. A wrong end detection shows as a pixel count that differs from max(|dx|,|dy|)+1, or as `done` missing or misplaced relative to the final pixel, and this is caught within one cycle of the expected end. A control state that wrongly accepts `start` while busy appears as a disturbed stream or as an extra line after `done`, both of which are checked at the ports.

// File: rtl/line_raster_pkg.sv
package line_raster_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture endpoints, initialise loop
    logic step;   // advance one pixel
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DRAW = 2'd1,
    ST_FIN  = 2'd2
  } rasterState_t;

endpackage

// File: rtl/line_raster_dp.sv
module line_raster_dp
  import line_raster_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  dpCtl_t             ctl,
  input  logic [COORD_W-1:0] xStart,
  input  logic [COORD_W-1:0] yStart,
  input  logic [COORD_W-1:0] xEnd,
  input  logic [COORD_W-1:0] yEnd,
  output logic [COORD_W-1:0] curX,
  output logic [COORD_W-1:0] curY,
  output logic               atEnd
);

  // Three extra bits: sign, doubling of err, and headroom for err+dx+dy
  localparam int ERR_W = COORD_W + 3;
  localparam int PAD_W = ERR_W - COORD_W;
  localparam logic [COORD_W-1:0]      ONE_C  = COORD_W'(1);
  localparam logic signed [ERR_W-1:0] ZERO_E = '0;

  // Endpoint differences, formed from the raw inputs at load time
  logic signed [ERR_W-1:0] diffX, diffY, absX, absY, errInit;

  always_comb begin
    diffX   = $signed({{PAD_W{1'b0}}, xEnd}) - $signed({{PAD_W{1'b0}}, xStart});
    diffY   = $signed({{PAD_W{1'b0}}, yEnd}) - $signed({{PAD_W{1'b0}}, yStart});
    absX    = diffX[ERR_W-1] ? -diffX : diffX;
    absY    = diffY[ERR_W-1] ? -diffY : diffY;
    errInit = absX - absY;
  end

  // Loop state
  logic [COORD_W-1:0]      endX, endY;
  logic signed [ERR_W-1:0] dxR, dyR, err;
  logic                    xNeg, yNeg;

  logic signed [ERR_W-1:0] e2, errNext;
  logic                    moveX, moveY;
  logic [COORD_W-1:0]      nextX, nextY;

  always_comb begin
    e2      = err <<< 1;
    moveX   = (e2 >= dyR);
    moveY   = (e2 <= dxR);
    errNext = err + (moveX ? dyR : ZERO_E) + (moveY ? dxR : ZERO_E);
    nextX   = curX;
    nextY   = curY;
    if (moveX) nextX = xNeg ? (curX - ONE_C) : (curX + ONE_C);
    if (moveY) nextY = yNeg ? (curY - ONE_C) : (curY + ONE_C);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      curX <= '0;
      curY <= '0;
      endX <= '0;
      endY <= '0;
      dxR  <= '0;
      dyR  <= '0;
      err  <= '0;
      xNeg <= 1'b0;
      yNeg <= 1'b0;
    end else if (ctl.load) begin
      curX <= xStart;
      curY <= yStart;
      endX <= xEnd;
      endY <= yEnd;
      dxR  <= absX;
      dyR  <= -absY;
      err  <= errInit;
      xNeg <= diffX[ERR_W-1];
      yNeg <= diffY[ERR_W-1];
    end else if (ctl.step) begin
      curX <= nextX;
      curY <= nextY;
      err  <= errNext;
    end
  end

  assign atEnd = (curX == endX) && (curY == endY);

  // R3
  pix_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.step |=> ((curX == $past(curX)) || (curX == $past(curX) + ONE_C) || (curX == $past(curX) - ONE_C)) &&
                 ((curY == $past(curY)) || (curY == $past(curY) + ONE_C) || (curY == $past(curY) - ONE_C)));

  // R3
  pix_moves_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.step |=> ((curX != $past(curX)) || (curY != $past(curY))));

  // R2
  load_origin_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> (curX == $past(xStart)) && (curY == $past(yStart)));

endmodule

// File: rtl/line_raster_ctrl.sv
module line_raster_ctrl
  import line_raster_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   atEnd,
  output dpCtl_t ctl,
  output logic   ready,
  output logic   pixValid,
  output logic   done
);

  rasterState_t state, stateNext;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) stateNext = ST_DRAW;
      ST_DRAW: if (atEnd) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.load = (state == ST_IDLE) && start;
    ctl.step = (state == ST_DRAW) && !atEnd;
  end

  assign ready    = (state == ST_IDLE);
  assign pixValid = (state == ST_DRAW);
  assign done     = (state == ST_FIN);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> (pixValid && !ready));

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (pixValid && atEnd) |=> (done && !pixValid));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && ready));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pixValid && !atEnd) |=> (pixValid && !ready));

endmodule

// File: rtl/line_raster.sv
module line_raster
  import line_raster_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [COORD_W-1:0] xStart,
  input  logic [COORD_W-1:0] yStart,
  input  logic [COORD_W-1:0] xEnd,
  input  logic [COORD_W-1:0] yEnd,
  output logic               ready,
  output logic               pixValid,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] pixY,
  output logic               done
);

  dpCtl_t ctl;
  logic   atEnd;

  line_raster_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .atEnd    (atEnd),
    .ctl      (ctl),
    .ready    (ready),
    .pixValid (pixValid),
    .done     (done)
  );

  line_raster_dp #(.COORD_W(COORD_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .xStart (xStart),
    .yStart (yStart),
    .xEnd   (xEnd),
    .yEnd   (yEnd),
    .curX   (pixX),
    .curY   (pixY),
    .atEnd  (atEnd)
  );

endmodule

// File: tb/line_raster_tb_top.sv
module line_raster_tb_top;

  localparam int W   = 8;
  localparam int MAXC = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] xStart = '0, yStart = '0, xEnd = '0, yEnd = '0;
  logic         ready, pixValid, done;
  logic [W-1:0] pixX, pixY;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  line_raster #(.COORD_W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .xStart(xStart), .yStart(yStart), .xEnd(xEnd), .yEnd(yEnd),
    .ready(ready), .pixValid(pixValid), .pixX(pixX), .pixY(pixY), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Draw one line and check it pixel by pixel; poke drives start while busy.
  task automatic drawLine(input int x0, input int y0, input int x1, input int y1,
                          input bit poke, input string req);
    int rx, ry, rdx, rdy, rsx, rsy, rerr, re2, cnt, px, py, guard, expCnt;
    guard = 0;
    while (ready !== 1'b1 && guard < 1000) begin @(negedge clk); guard++; end
    chk(ready === 1'b1, "R2", "ready before start", int'(ready), 1);
    xStart = W'(x0); yStart = W'(y0); xEnd = W'(x1); yEnd = W'(y1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ready === 1'b0, "R2", "ready after accept", int'(ready), 0);
    // reference loop
    rx = x0; ry = y0;
    rdx = iabs(x1 - x0); rdy = -iabs(y1 - y0);
    rsx = (x1 >= x0) ? 1 : -1; rsy = (y1 >= y0) ? 1 : -1;
    rerr = rdx + rdy;
    cnt = 0; px = x0; py = y0;
    for (int k = 0; k < 4 * MAXC + 8; k++) begin
      chk(pixValid === 1'b1 && int'(pixX) == rx && int'(pixY) == ry, req,
          "pixel x*1000+y", int'(pixX) * 1000 + int'(pixY), rx * 1000 + ry);
      if (cnt > 0)
        chk(iabs(int'(pixX) - px) <= 1 && iabs(int'(pixY) - py) <= 1 &&
            !(int'(pixX) == px && int'(pixY) == py),
            "R3", "step x*1000+y", int'(pixX) * 1000 + int'(pixY), px * 1000 + py);
      px = int'(pixX); py = int'(pixY);
      if (poke && cnt == 1) begin
        // R8: new endpoints presented while busy
        start = 1'b1;
        xStart = W'(x1); yStart = W'(y1); xEnd = W'(x0); yEnd = W'(y0);
      end
      cnt++;
      if (rx == x1 && ry == y1) break;
      re2 = 2 * rerr;
      if (re2 >= rdy) begin rerr += rdy; rx += rsx; end
      if (re2 <= rdx) begin rerr += rdx; ry += rsy; end
      @(negedge clk);
    end
    @(negedge clk);
    chk(done === 1'b1 && pixValid === 1'b0 && ready === 1'b0, "R7", "done cycle d/v/r",
        int'(done) * 100 + int'(pixValid) * 10 + int'(ready), 100);
    start = 1'b0;
    expCnt = ((rdx > -rdy) ? rdx : -rdy) + 1;
    chk(cnt == expCnt, "R5", "pixel count", cnt, expCnt);
    chk(px == x1 && py == y1, "R5", "last pixel x*1000+y", px * 1000 + py, x1 * 1000 + y1);
    @(negedge clk);
    chk(done === 1'b0 && ready === 1'b1, "R7", "after done d/r",
        int'(done) * 10 + int'(ready), 1);
    if (poke) begin
      @(negedge clk);
      chk(ready === 1'b1 && pixValid === 1'b0, "R8", "no line after busy start r/v",
          int'(ready) * 10 + int'(pixValid), 10);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(ready === 1'b1 && pixValid === 1'b0 && done === 1'b0, "R1", "in reset r/v/d",
        int'(ready) * 100 + int'(pixValid) * 10 + int'(done), 100);
    rst = 1'b0;
    @(negedge clk);
    chk(ready === 1'b1 && pixValid === 1'b0 && done === 1'b0, "R1", "after reset r/v/d",
        int'(ready) * 100 + int'(pixValid) * 10 + int'(done), 100);
  endtask

  task automatic testOctants();
    // R4 / R9: all eight octants around (100,100)
    drawLine(100, 100, 130, 110, 1'b0, "R4");
    drawLine(100, 100, 110, 130, 1'b0, "R4");
    drawLine(100, 100,  90, 130, 1'b0, "R4");
    drawLine(100, 100,  70, 110, 1'b0, "R4");
    drawLine(100, 100,  70,  90, 1'b0, "R9");
    drawLine(100, 100,  90,  70, 1'b0, "R9");
    drawLine(100, 100, 110,  70, 1'b0, "R9");
    drawLine(100, 100, 130,  90, 1'b0, "R9");
  endtask

  task automatic testAxes();
    // R9: horizontal, vertical and diagonal
    drawLine(5, 40, 60, 40, 1'b0, "R9");
    drawLine(60, 40, 5, 40, 1'b0, "R9");
    drawLine(33, 2, 33, 50, 1'b0, "R9");
    drawLine(33, 50, 33, 2, 1'b0, "R9");
    drawLine(10, 10, 30, 30, 1'b0, "R4");
  endtask

  task automatic testSinglePoint();
    // R6: start equals end
    drawLine(77, 12, 77, 12, 1'b0, "R6");
    drawLine(0, 0, 0, 0, 1'b0, "R6");
  endtask

  task automatic testFullRange();
    // R9: extreme coordinates
    drawLine(0, 0, MAXC, MAXC, 1'b0, "R9");
    drawLine(MAXC, 0, 0, 3, 1'b0, "R9");
    drawLine(0, MAXC, MAXC, 0, 1'b0, "R9");
    drawLine(MAXC, MAXC, 1, 200, 1'b0, "R9");
  endtask

  task automatic testBusyStart();
    // R8: start held during drawing and done cycle is ignored
    drawLine(20, 200, 45, 180, 1'b1, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testOctants();
    testAxes();
    testSinglePoint();
    testFullRange();
    testBusyStart();
    drawLine(3, 4, 9, 1, 1'b0, "R2");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule